// File: doc/BRIEF.md
# Fetch Address and Exception Entry Sequencer

This block owns the fetch address of a three-stage fetch, decode and execute pipeline with 32-bit, word-aligned instructions. While an instruction is in execute, the fetch address sits two instructions ahead of it, at its address plus 8. The block reports when the execute stage holds a valid instruction. When the pipeline is full it accepts a branch strobe from execute, or an exception request.

A taken branch adds its sign-extended, word-scaled 24-bit offset to the current fetch address. When the link bit is set, it also asks for the return address to be written to the link register. Exception entry chooses one request by fixed priority and applies the interrupt masks from the current status word. It then jumps to a fixed vector and outputs the new status word, with the new mode, the interrupt-disable bits and the state bit cleared, together with the return address.

The status register, the saved copy of it, the register file, the memory and the decoder all sit outside this block. It drives their write strobes and data.

Top module: `fetch_seq`

## Requirements
- R1: While rst_ni is low and for the first cycle after its release, pc_o is 0, exec_valid_o is 0, flush_o and link_we_o are 0, and exc_take_o is 1. In that state status_o equals status_i with mode bits [4:0] = 5'b10011, bit 7 (I) = 1, bit 6 (F) = 1 and bit 5 (T) = 0.
- R2: In a cycle with flush_o = 0, pc_o advances by 4 at the next clock edge.
- R3: exec_valid_o is 0 for the two cycles that follow a flush or reset and is 1 in the third. The execute stage therefore restarts 3 cycles after a redirect, with pc_o = target + 8.
- R4: A branch accepted with exec_valid_o = 1 raises flush_o in that cycle. The next pc_o is pc_o + sign_extend(br_off_i << 2).
- R5: An accepted branch with br_link_i = 1 sets link_we_o with link_o = pc_o - 4. With br_link_i = 0, link_we_o stays 0.
- R6: A branch strobe while exec_valid_o = 0 has no effect: there is no flush and no link write, and pc_o advances by 4.
- R7: An exception taken jumps to its vector and mode: undefined 0x04/11011, software interrupt 0x08/10011, prefetch abort 0x0C/10111, data abort 0x10/10111, IRQ 0x18/10010, FIQ 0x1C/10001.
- R8: The priority from highest to lowest is data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R9: status_i bit 7 (I) masks irq_i and status_i bit 6 (F) masks fiq_i. A masked request does not block a lower-priority one.
- R10: On exception entry status_o sets bit 7 and clears bit 5. It sets bit 6 only for FIQ and otherwise keeps status_i bit 6. It keeps status_i[31:8]. With no entry, status_o equals status_i.
- R11: An exception wins over a branch in the same cycle. Every exception entry sets flush_o and link_we_o with link_o = pc_o - 4.
- R12: Exception requests while exec_valid_o = 0 are ignored: exc_take_o stays 0 and pc_o advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Branch executed this cycle |
| br_off_i | input | 24 | Branch word offset |
| br_link_i | input | 1 | Branch writes link register |
| dabt_i | input | 1 | Data abort request |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Normal interrupt request |
| pabt_i | input | 1 | Prefetch abort request |
| undef_i | input | 1 | Undefined instruction request |
| swi_i | input | 1 | Software interrupt request |
| status_i | input | 32 | Current status word |
| pc_o | output | 32 | Fetch address |
| exec_valid_o | output | 1 | Execute stage holds a valid instruction |
| flush_o | output | 1 | Redirect this cycle; discard fetch and decode |
| link_we_o | output | 1 | Write link register of the new/current mode |
| link_o | output | 32 | Link value |
| exc_take_o | output | 1 | Exception entry; save status_i and write status_o |
| status_o | output | 32 | New status word |

## Verification
On every cycle the assertions check the following: the fetch address stays word aligned, it steps by 4 whenever there is no redirect, the pipeline is empty right after a flush, a link write only happens along with a redirect, a masked interrupt is never taken, and each entry sets I and clears T. Only the bench scenarios can show the exact branch targets at the offset extremes, the vector and mode for each cause, the priority order under combined requests, and that a masked request lets a lower one through. The same holds for F being preserved when the entry is not FIQ, and for strobes being ignored while the pipeline refills.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  localparam int NUM_EXC = 6;

  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int ST_I = 7;
  localparam int ST_F = 6;
  localparam int ST_T = 5;

  // request index order is priority order, 0 highest
  typedef enum logic [2:0] {
    EX_NONE, EX_DABT, EX_FIQ, EX_IRQ, EX_PABT, EX_UNDEF, EX_SWI
  } exc_e;

  function automatic logic [4:0] vec_of(exc_e k);
    case (k)
      EX_UNDEF: vec_of = 5'h04;
      EX_SWI:   vec_of = 5'h08;
      EX_PABT:  vec_of = 5'h0C;
      EX_DABT:  vec_of = 5'h10;
      EX_IRQ:   vec_of = 5'h18;
      EX_FIQ:   vec_of = 5'h1C;
      default:  vec_of = 5'h00;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(exc_e k);
    case (k)
      EX_UNDEF:         mode_of = MODE_UND;
      EX_PABT, EX_DABT: mode_of = MODE_ABT;
      EX_IRQ:           mode_of = MODE_IRQ;
      EX_FIQ:           mode_of = MODE_FIQ;
      default:          mode_of = MODE_SVC;
    endcase
  endfunction
endpackage

// File: rtl/fetch_seq_target.sv
module fetch_seq_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 24
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] disp;
  assign disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign target_o = pc_i + disp;
endmodule

// File: rtl/fetch_seq_fill.sv
module fetch_seq_fill #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic valid_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (cnt_q != FULL)     cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == FULL);

  // R3: a restart empties execute on the next cycle
  a_r3_restart_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !valid_o);
endmodule

// File: rtl/fetch_seq_arb.sv
module fetch_seq_arb
  import fetch_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXC-1:0] req_i,
  input  logic               i_mask_i,
  input  logic               f_mask_i,
  output logic               take_o,
  output exc_e               kind_o
);
  logic [NUM_EXC-1:0] eff;

  for (genvar gi = 0; gi < NUM_EXC; gi++) begin : g_mask
    if (gi == 1)      begin : g_fiq assign eff[gi] = req_i[gi] & ~f_mask_i; end
    else if (gi == 2) begin : g_irq assign eff[gi] = req_i[gi] & ~i_mask_i; end
    else              begin : g_raw assign eff[gi] = req_i[gi]; end
  end

  logic [2:0] sel;
  always_comb begin
    sel = '0;
    for (int k = NUM_EXC - 1; k >= 0; k--)
      if (eff[k]) sel = 3'(k);
  end

  assign take_o = |eff;
  assign kind_o = take_o ? exc_e'(sel + 3'd1) : EX_NONE;

  // R9: masked interrupts are never granted
  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && kind_o == EX_IRQ) |-> !i_mask_i);
  a_r9_fiq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && kind_o == EX_FIQ) |-> !f_mask_i);
  // R8: data abort always wins when present
  a_r8_dabt_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> (kind_o == EX_DABT));
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int OFF_W      = 24,
  parameter int FILL_DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_valid_i,
  input  logic [OFF_W-1:0] br_off_i,
  input  logic             br_link_i,
  input  logic             dabt_i,
  input  logic             fiq_i,
  input  logic             irq_i,
  input  logic             pabt_i,
  input  logic             undef_i,
  input  logic             swi_i,
  input  logic [XLEN-1:0]  status_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             exec_valid_o,
  output logic             flush_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_o,
  output logic             exc_take_o,
  output logic [XLEN-1:0]  status_o
);
  localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

  logic [XLEN-1:0]    pc_q, pc_d, br_target;
  logic               rst_pend_q, accept, exc_go, br_go, set_f;
  logic [NUM_EXC-1:0] req;
  exc_e               kind;
  logic [4:0]         new_mode;

  assign accept = exec_valid_o & ~rst_pend_q;
  assign req    = {swi_i, undef_i, pabt_i, irq_i, fiq_i, dabt_i} & {NUM_EXC{accept}};

  fetch_seq_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .i_mask_i (status_i[ST_I]),
    .f_mask_i (status_i[ST_F]),
    .take_o   (exc_go),
    .kind_o   (kind)
  );

  fetch_seq_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_target (
    .pc_i     (pc_q),
    .off_i    (br_off_i),
    .target_o (br_target)
  );

  fetch_seq_fill #(.DEPTH(FILL_DEPTH)) u_fill (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (flush_o),
    .valid_o   (exec_valid_o)
  );

  assign br_go = accept & br_valid_i & ~exc_go;

  always_comb begin
    if (exc_go)     pc_d = {{(XLEN-5){1'b0}}, vec_of(kind)};
    else if (br_go) pc_d = br_target;
    else            pc_d = pc_q + INSTR_BYTES;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      rst_pend_q <= 1'b1;
    end else begin
      pc_q       <= pc_d;
      rst_pend_q <= 1'b0;
    end
  end

  // reset entry reports as an exception with the supervisor mode
  assign new_mode = rst_pend_q ? MODE_SVC : mode_of(kind);
  assign set_f    = rst_pend_q | (kind == EX_FIQ);

  always_comb begin
    status_o = status_i;
    if (exc_take_o) begin
      status_o[4:0]  = new_mode;
      status_o[ST_T] = 1'b0;
      status_o[ST_F] = status_i[ST_F] | set_f;
      status_o[ST_I] = 1'b1;
    end
  end

  assign pc_o       = pc_q;
  assign flush_o    = exc_go | br_go;
  assign link_we_o  = exc_go | (br_go & br_link_i);
  assign link_o     = pc_q - INSTR_BYTES;
  assign exc_take_o = rst_pend_q | exc_go;

  a_r1_pc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
  a_r2_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_o |=> pc_o == $past(pc_o) + INSTR_BYTES);
  a_r5_link_needs_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> flush_o);
  a_r10_entry_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_o |-> (status_o[ST_I] && !status_o[ST_T]));
  a_r11_vector_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take_o && flush_o) |=> (pc_o[XLEN-1:5] == '0));
endmodule

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_valid_i = 1'b0;
  logic [23:0] br_off_i = '0;
  logic        br_link_i = 1'b0;
  logic [5:0]  req = '0; // [0]dabt [1]fiq [2]irq [3]pabt [4]undef [5]swi
  logic [31:0] status_i = 32'hF000_0010;
  logic [31:0] pc_o, link_o, status_o;
  logic        exec_valid_o, flush_o, link_we_o, exc_take_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .br_valid_i(br_valid_i), .br_off_i(br_off_i),
    .br_link_i(br_link_i), .dabt_i(req[0]), .fiq_i(req[1]), .irq_i(req[2]),
    .pabt_i(req[3]), .undef_i(req[4]), .swi_i(req[5]), .status_i(status_i),
    .pc_o(pc_o), .exec_valid_o(exec_valid_o), .flush_o(flush_o),
    .link_we_o(link_we_o), .link_o(link_o), .exc_take_o(exc_take_o),
    .status_o(status_o)
  );

  // {offset, link, expected displacement}
  localparam logic [56:0] BR_TAB [6] = '{
    {24'h000001, 1'b0, 32'h0000_0004},
    {24'hFFFFFF, 1'b1, 32'hFFFF_FFFC},
    {24'h7FFFFF, 1'b0, 32'h01FF_FFFC},
    {24'h800000, 1'b1, 32'hFE00_0000},
    {24'h000010, 1'b1, 32'h0000_0040},
    {24'hFFFFFE, 1'b0, 32'hFFFF_FFF8}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    @(negedge clk);
    while (!exec_valid_o) @(negedge clk);
  endtask

  task automatic clear_in();
    br_valid_i = 1'b0; br_link_i = 1'b0; br_off_i = '0; req = '0;
  endtask

  task automatic exc_case(input string tag, input logic [5:0] r, input logic [31:0] st,
                          input logic exp_take, input logic [31:0] exp_vec,
                          input logic [31:0] exp_st, input logic with_br);
    logic [31:0] p;
    wait_valid();
    p = pc_o;
    req = r; status_i = st;
    br_valid_i = with_br; br_off_i = 24'h000010; br_link_i = with_br;
    #1;
    check({tag, " take"}, {31'd0, exc_take_o}, {31'd0, exp_take});
    if (exp_take) begin
      check({tag, " R11 flush"}, {31'd0, flush_o}, 32'd1);
      check({tag, " R11 link_we"}, {31'd0, link_we_o}, 32'd1);
      check({tag, " R11 link"}, link_o, p - 32'd4);
      check({tag, " R10 status"}, status_o, exp_st);
    end else begin
      check({tag, " R9 no flush"}, {31'd0, flush_o}, 32'd0);
      check({tag, " R10 status pass"}, status_o, st);
    end
    @(posedge clk); #1;
    check({tag, " R7 pc"}, pc_o, exp_take ? exp_vec : p + 32'd4);
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #7;
    check("R1 pc", pc_o, 32'h0);
    check("R1 exec_valid", {31'd0, exec_valid_o}, 32'd0);
    check("R1 take", {31'd0, exc_take_o}, 32'd1);
    check("R1 status", status_o, 32'hF000_00D3);
    check("R1 flush", {31'd0, flush_o}, 32'd0);
    check("R1 link_we", {31'd0, link_we_o}, 32'd0);
    @(negedge clk); rst_ni = 1'b1; #1;
    check("R1 take after release", {31'd0, exc_take_o}, 32'd1);
    @(posedge clk); #1;
    check("R1 pc step", pc_o, 32'h4);
    check("R1 take cleared", {31'd0, exc_take_o}, 32'd0);
    check("R3 not valid", {31'd0, exec_valid_o}, 32'd0);
    // R6 / R12: strobes while refilling
    @(negedge clk);
    br_valid_i = 1'b1; br_off_i = 24'h000010; br_link_i = 1'b1; req = 6'b000100;
    status_i = 32'h0000_0010; #1;
    check("R6 no flush", {31'd0, flush_o}, 32'd0);
    check("R6 no link", {31'd0, link_we_o}, 32'd0);
    check("R12 no take", {31'd0, exc_take_o}, 32'd0);
    @(posedge clk); #1;
    check("R6 pc", pc_o, 32'h8);
    check("R3 valid", {31'd0, exec_valid_o}, 32'd1);
    @(negedge clk); clear_in();

    // branch table
    for (int i = 0; i < 6; i++) begin
      logic [31:0] p, t;
      wait_valid();
      p = pc_o;
      t = p + BR_TAB[i][31:0];
      br_valid_i = 1'b1; br_off_i = BR_TAB[i][56:33]; br_link_i = BR_TAB[i][32];
      #1;
      check("R4 flush", {31'd0, flush_o}, 32'd1);
      check("R5 link_we", {31'd0, link_we_o}, {31'd0, BR_TAB[i][32]});
      if (BR_TAB[i][32]) check("R5 link", link_o, p - 32'd4);
      @(posedge clk); #1;
      check("R4 target", pc_o, t);
      check("R3 drained", {31'd0, exec_valid_o}, 32'd0);
      @(negedge clk); clear_in();
      @(posedge clk); #1;
      check("R2 step", pc_o, t + 32'd4);
      check("R3 second", {31'd0, exec_valid_o}, 32'd0);
      @(posedge clk); #1;
      check("R3 refill", {31'd0, exec_valid_o}, 32'd1);
      check("R3 pc ahead", pc_o, t + 32'd8);
    end

    // R7 single causes, status T=1, user mode, unmasked
    exc_case("R7 undef", 6'b010000, 32'hA000_0030, 1, 32'h04, 32'hA000_009B, 0);
    exc_case("R7 swi",   6'b100000, 32'hA000_0030, 1, 32'h08, 32'hA000_0093, 0);
    exc_case("R7 pabt",  6'b001000, 32'hA000_0030, 1, 32'h0C, 32'hA000_0097, 0);
    exc_case("R7 dabt",  6'b000001, 32'hA000_0030, 1, 32'h10, 32'hA000_0097, 0);
    exc_case("R7 irq",   6'b000100, 32'hA000_0030, 1, 32'h18, 32'hA000_0092, 0);
    exc_case("R7 fiq",   6'b000010, 32'hA000_0030, 1, 32'h1C, 32'hA000_00D1, 0);
    // R8 priority
    exc_case("R8 all",      6'b111111, 32'hA000_0030, 1, 32'h10, 32'hA000_0097, 0);
    exc_case("R8 fiq>irq",  6'b001110, 32'hA000_0030, 1, 32'h1C, 32'hA000_00D1, 0);
    exc_case("R8 irq>pabt", 6'b011100, 32'hA000_0030, 1, 32'h18, 32'hA000_0092, 0);
    exc_case("R8 pabt>und", 6'b111000, 32'hA000_0030, 1, 32'h0C, 32'hA000_0097, 0);
    exc_case("R8 und>swi",  6'b110000, 32'hA000_0030, 1, 32'h04, 32'hA000_009B, 0);
    // R9 masking
    exc_case("R9 irq masked", 6'b000100, 32'hA000_00B0, 0, 32'h0, 32'h0, 0);
    exc_case("R9 fiq masked", 6'b000010, 32'hA000_0070, 0, 32'h0, 32'h0, 0);
    exc_case("R9 I lets fiq", 6'b000110, 32'hA000_00B0, 1, 32'h1C, 32'hA000_00D1, 0);
    exc_case("R9 F lets irq", 6'b000110, 32'hA000_0070, 1, 32'h18, 32'hA000_00D2, 0);
    // R10 F kept on non-FIQ entry
    exc_case("R10 keep F", 6'b000001, 32'h5000_0070, 1, 32'h10, 32'h5000_00D7, 0);
    // R11 exception beats branch
    exc_case("R11 irq+br", 6'b000100, 32'hA000_0030, 1, 32'h18, 32'hA000_0092, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule